// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked system to an external asynchronous byte-wide static RAM with a 21-bit address and an 8-bit data bus. A client issues one read or one write at a time over a valid/ready handshake. The controller then drives the active-low chip-select, write-strobe and output-strobe pins, holds the address, and enables the data bus only while a write is in progress. Read data comes back with a one-cycle response pulse.

All strobe phases are timed by down-counters. Their lengths are worked out when the block is built, from nanosecond timing parameters and the clock period. Each phase length is the nanosecond figure divided by the period, rounded up to whole cycles, and never less than one. After reset the block waits out a power-up interval before it accepts its first request. The data bus is split into an output, an output-enable and an input, and the bidirectional pad is built outside the block.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low for exactly ceil(POWERUP_NS/CLK_PERIOD_NS) clock cycles and then goes high. A request presented during this wait causes no strobe activity.
- R2: While reset is asserted and while the controller is idle, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are all 1 and `sram_dq_oe` is 0. Asserting reset in the middle of an access returns them to this state one clock later.
- R3: A write holds `sram_ce_n` low with `sram_we_n` high for ceil(T_SA_NS/P) cycles (minimum 1). It then holds `sram_we_n` low for ceil(max(T_PWE_NS, T_SD_NS, T_AW_NS)/P) cycles.
- R4: `sram_dq_oe` is 1 exactly in the cycles where `sram_ce_n` and `sram_we_n` are both 0, and during those cycles `sram_dq_out` carries the accepted write byte.
- R5: `sram_oe_n` stays 1 for the whole of a write, and `sram_we_n` stays 1 for the whole of a read.
- R6: `sram_addr` equals the accepted request address in every cycle where `sram_ce_n` is 0. Changes on `req_addr` or `req_wdata` after acceptance have no effect.
- R7: A read holds `sram_ce_n` and `sram_oe_n` low for ceil(max(T_AA_NS, T_RC_NS, T_DOE_NS)/P) cycles. The bus is sampled at the clock edge that ends this wait. In the next cycle `rsp_valid` is 1 for one cycle with that byte on `rsp_rdata`, and all strobes are high.
- R8: After the strobe pulse, a write keeps `sram_ce_n` low with `sram_we_n` high and the bus released for at least one cycle. The total span with `sram_ce_n` low is max(ceil(T_WC_NS/P), setup + pulse + 1) cycles.
- R9: `req_ready` is 0 from the acceptance edge until the access has finished: write span + 0 cycles for writes, read wait + 1 capture cycle for reads. Only one request is in flight at a time, and a new request is accepted in the first idle cycle.
- R10: A write never produces `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 21 | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Pad drive enable for sram_dq_out |
| sram_dq_in | input | 8 | Data from the memory |

## Verification
The bench's memory model returns garbage until the read strobes have been low for the computed access time. A controller that samples one edge too early therefore returns the wrong byte. The bench counts the cycles of each strobe phase, so a rounding error or an off-by-one in a phase counter shows up as a wrong count. A missing recovery cycle shows up as a short chip-select span. The bench changes the request fields after acceptance, which exposes an address or data path that is not latched. It also resets the block in the middle of a write to show that the strobes fall back and the power-up wait restarts.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int ADDR_W = 21;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_RD_WAIT,
        ST_RD_CAPTURE
    } seq_state_t;

    typedef struct packed {
        logic              is_write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } access_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    // whole clock cycles covering a span in ns, never fewer than one
    function automatic int ns_to_cycles(input int span_ns, input int period_ns);
        int c;
        c = (span_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // pin levels belonging to each sequencer state
    function automatic strobe_t strobes_for(input seq_state_t s);
        strobe_t o;
        o = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        case (s)
            ST_WR_SETUP:   o.ce_n = 1'b0;
            ST_WR_PULSE: begin
                o.ce_n  = 1'b0;
                o.we_n  = 1'b0;
                o.dq_oe = 1'b1;
            end
            ST_WR_RECOVER: o.ce_n = 1'b0;
            ST_RD_WAIT: begin
                o.ce_n = 1'b0;
                o.oe_n = 1'b0;
            end
            default:       ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/asram_powerup.sv
module asram_powerup #(
    parameter int WAIT_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int W = $clog2(WAIT_CYC + 1);

    logic [W-1:0] cnt_q;
    logic         done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == W'(WAIT_CYC - 1)) done_q <= 1'b1;
            else                           cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign done = done_q;
endmodule

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int PH_W      = 4,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 1,
    parameter int RECOV_CYC = 1,
    parameter int READ_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              powered,
    input  logic              req_valid,
    input  access_t           req_in,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output strobe_t           pins,
    output logic [DATA_W-1:0] dq_out,
    input  logic [DATA_W-1:0] dq_in
);
    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    strobe_t           pins_q;
    logic              rsp_q;
    logic              ph_load, ph_done;
    logic [PH_W-1:0]   ph_val;
    logic              accept;

    assign req_ready = powered && (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    asram_phase_cnt #(.W(PH_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .load     (ph_load),
        .load_val (ph_val),
        .done     (ph_done)
    );

    always_comb begin
        state_d = state_q;
        ph_load = 1'b0;
        ph_val  = '0;
        case (state_q)
            ST_IDLE: if (accept) begin
                ph_load = 1'b1;
                if (req_in.is_write) begin
                    state_d = ST_WR_SETUP;
                    ph_val  = PH_W'(SETUP_CYC - 1);
                end else begin
                    state_d = ST_RD_WAIT;
                    ph_val  = PH_W'(READ_CYC - 1);
                end
            end
            ST_WR_SETUP: if (ph_done) begin
                state_d = ST_WR_PULSE;
                ph_load = 1'b1;
                ph_val  = PH_W'(PULSE_CYC - 1);
            end
            ST_WR_PULSE: if (ph_done) begin
                state_d = ST_WR_RECOVER;
                ph_load = 1'b1;
                ph_val  = PH_W'(RECOV_CYC - 1);
            end
            ST_WR_RECOVER: if (ph_done) state_d = ST_IDLE;
            ST_RD_WAIT:    if (ph_done) state_d = ST_RD_CAPTURE;
            ST_RD_CAPTURE: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins_q  <= strobes_for(ST_IDLE);
            rsp_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            pins_q  <= strobes_for(state_d);
            rsp_q   <= (state_d == ST_RD_CAPTURE);
            if (accept) begin
                addr_q  <= req_in.addr;
                wdata_q <= req_in.wdata;
            end
            if (state_q == ST_RD_WAIT && ph_done) rdata_q <= dq_in;
        end
    end

    assign pins      = pins_q;
    assign mem_addr  = addr_q;
    assign dq_out    = wdata_q;
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int POWERUP_NS    = 1_000_000,
    parameter int T_RC_NS       = 10,
    parameter int T_AA_NS       = 10,
    parameter int T_DOE_NS      = 5,
    parameter int T_WC_NS       = 10,
    parameter int T_PWE_NS      = 7,
    parameter int T_AW_NS       = 7,
    parameter int T_SA_NS       = 0,
    parameter int T_SD_NS       = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int P         = CLK_PERIOD_NS;
    localparam int WAIT_CYC  = ns_to_cycles(POWERUP_NS, P);
    localparam int SETUP_CYC = ns_to_cycles(T_SA_NS, P);
    localparam int PULSE_CYC = ns_to_cycles(imax(T_PWE_NS, imax(T_SD_NS, T_AW_NS)), P);
    localparam int WC_CYC    = ns_to_cycles(T_WC_NS, P);
    localparam int RECOV_CYC = imax(1, WC_CYC - SETUP_CYC - PULSE_CYC);
    localparam int READ_CYC  = ns_to_cycles(imax(imax(T_AA_NS, T_RC_NS), T_DOE_NS), P);
    localparam int PH_MAX    = imax(imax(SETUP_CYC, PULSE_CYC), imax(RECOV_CYC, READ_CYC));
    localparam int PH_W      = $clog2(PH_MAX + 1);

    logic    powered;
    access_t req_in;
    strobe_t pins;

    assign req_in = '{is_write: req_write, addr: req_addr, wdata: req_wdata};

    asram_powerup #(.WAIT_CYC(WAIT_CYC)) u_pwr (
        .clk  (clk),
        .rst  (rst),
        .done (powered)
    );

    asram_seq #(
        .PH_W      (PH_W),
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .RECOV_CYC (RECOV_CYC),
        .READ_CYC  (READ_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .powered   (powered),
        .req_valid (req_valid),
        .req_in    (req_in),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (sram_addr),
        .pins      (pins),
        .dq_out    (sram_dq_out),
        .dq_in     (sram_dq_in)
    );

    assign sram_ce_n  = pins.ce_n;
    assign sram_we_n  = pins.we_n;
    assign sram_oe_n  = pins.oe_n;
    assign sram_dq_oe = pins.dq_oe;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        sram_ce_n,
    input logic        sram_we_n,
    input logic        sram_oe_n,
    input logic        sram_dq_oe,
    input logic [20:0] sram_addr
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    p_drive_in_window_r4: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> (!sram_ce_n && !sram_we_n));

    p_window_drives_r4: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && !sram_we_n) |-> sram_dq_oe);

    p_no_oe_in_write_r5: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> sram_oe_n);

    p_no_we_in_read_r5: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> sram_we_n);

    p_setup_before_we_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> !$past(sram_ce_n));

    p_addr_held_r6: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

    p_rsp_single_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!$past(sram_oe_n) && sram_ce_n));

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> !req_ready);
endmodule

bind asram_ctrl asram_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe),
    .sram_addr  (sram_addr)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
    // expected figures from the requirement formulas at a 20 ns period
    localparam int EXP_WAIT  = 100; // 2000/20
    localparam int EXP_SETUP = 1;   // T_SA 0 -> min 1
    localparam int EXP_PULSE = 2;   // max(35,6,7)=35 -> 2
    localparam int EXP_WSPAN = 5;   // ceil(100/20)=5 >= 1+2+1
    localparam int EXP_READ  = 3;   // max(55,10,5)=55 -> 3
    localparam int NVEC      = 8;

    // {write, addr, data}; for reads data is the expected byte
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b1, 21'h000012, 8'hA5},
        {1'b1, 21'h1FFF34, 8'h3C},
        {1'b1, 21'h0ABC56, 8'hFF},
        {1'b0, 21'h000012, 8'hA5},
        {1'b0, 21'h1FFF34, 8'h3C},
        {1'b1, 21'h000012, 8'h00},
        {1'b0, 21'h000012, 8'h00},
        {1'b0, 21'h0ABC56, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [20:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_out, sram_dq_in;

    int errs = 0;
    int checks = 0;

    always #10 clk = ~clk;

    asram_ctrl #(
        .CLK_PERIOD_NS (20),
        .POWERUP_NS    (2000),
        .T_AA_NS       (55),
        .T_WC_NS       (100),
        .T_PWE_NS      (35)
    ) u_dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .sram_addr (sram_addr), .sram_ce_n (sram_ce_n), .sram_we_n (sram_we_n),
        .sram_oe_n (sram_oe_n), .sram_dq_out (sram_dq_out), .sram_dq_oe (sram_dq_oe),
        .sram_dq_in (sram_dq_in)
    );

    // memory model: garbage until the read strobes have been low long enough
    logic [7:0] mem [256];
    int         rd_cnt = 0;
    logic       rd_en;
    assign rd_en = !sram_ce_n && !sram_oe_n && sram_we_n;
    always @(posedge clk) rd_cnt <= rd_en ? rd_cnt + 1 : 0;
    always @(negedge clk)
        if (!sram_ce_n && !sram_we_n && sram_dq_oe) mem[sram_addr[7:0]] <= sram_dq_out;
    assign sram_dq_in = (rd_en && rd_cnt >= EXP_READ - 1) ? mem[sram_addr[7:0]] : 8'hEE;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // waits out power-up with a request held; returns wait length
    task automatic powerup_wait(output int n, output int moves);
        n = 0;
        moves = 0;
        req_valid = 1'b1;
        req_write = 1'b1;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            n++;
            if (!sram_ce_n || !sram_we_n) moves++;
            if (req_ready) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic do_op(input bit w, input logic [20:0] a, input logic [7:0] d);
        int busy = 0, ce_lo = 0, we_lo = 0, oe_lo = 0, rsp_n = 0;
        int bad_addr = 0, bad_win = 0, bad_data = 0, first_we = 0, rec_ok = 0;
        logic [7:0] got = '0;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        for (int k = 0; k < 64; k++) begin
            if (req_ready) break;
            if (k == 0) first_we = sram_we_n;
            busy++;
            if (!sram_ce_n) ce_lo++;
            if (!sram_we_n) we_lo++;
            if (!sram_oe_n) oe_lo++;
            if (!sram_ce_n && sram_addr != a) bad_addr++;
            if (sram_dq_oe != (!sram_ce_n && !sram_we_n)) bad_win++;
            if (sram_dq_oe && sram_dq_out != d) bad_data++;
            if (w && we_lo > 0 && sram_we_n && !sram_ce_n && !sram_dq_oe) rec_ok++;
            if (rsp_valid) begin rsp_n++; got = rsp_rdata; end
            @(negedge clk);
        end
        chk(!sram_dq_oe && sram_ce_n, "R2 idle after access", sram_ce_n, 1);
        chk(bad_addr == 0, "R6 address held", bad_addr, 0);
        chk(bad_win == 0 && bad_data == 0, "R4 bus window", bad_win + bad_data, 0);
        if (w) begin
            chk(first_we == 1, "R3 setup phase we_n high", first_we, 1);
            chk(we_lo == EXP_PULSE, "R3 pulse length", we_lo, EXP_PULSE);
            chk(oe_lo == 0, "R5 oe_n high in write", oe_lo, 0);
            chk(ce_lo == EXP_WSPAN && rec_ok >= 1, "R8 write span", ce_lo, EXP_WSPAN);
            chk(busy == EXP_WSPAN, "R9 busy write", busy, EXP_WSPAN);
            chk(rsp_n == 0, "R10 no response on write", rsp_n, 0);
        end else begin
            chk(we_lo == 0, "R5 we_n high in read", we_lo, 0);
            chk(oe_lo == EXP_READ && ce_lo == EXP_READ, "R7 read wait", oe_lo, EXP_READ);
            chk(rsp_n == 1, "R7 single response", rsp_n, 1);
            chk(got == d, "R7 read data", got, d);
            chk(busy == EXP_READ + 1, "R9 busy read", busy, EXP_READ + 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R9 watchdog: actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        int n, moves;
        for (int i = 0; i < 256; i++) mem[i] = 8'h77;
        repeat (3) @(negedge clk);
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R2 reset strobes", {sram_ce_n, sram_we_n, sram_oe_n}, 7);
        chk(!sram_dq_oe, "R2 reset bus released", sram_dq_oe, 0);
        chk(!req_ready, "R1 not ready in reset", req_ready, 0);
        rst = 1'b0;
        powerup_wait(n, moves);
        chk(n == EXP_WAIT, "R1 power-up length", n, EXP_WAIT);
        chk(moves == 0, "R1 request ignored during wait", moves, 0);

        for (int i = 0; i < NVEC; i++)
            do_op(VEC[i][29], VEC[i][28:8], VEC[i][7:0]);

        // reset in the middle of a write
        req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h000099; req_wdata = 8'h42;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!sram_we_n, "R3 pulse reached before reset", sram_we_n, 0);
        rst = 1'b1;
        @(negedge clk);
        chk(sram_ce_n && sram_we_n && !sram_dq_oe, "R2 mid-access reset", {sram_ce_n, sram_we_n, sram_dq_oe}, 6);
        chk(!req_ready, "R1 not ready after reset", req_ready, 0);
        rst = 1'b0;
        powerup_wait(n, moves);
        chk(n == EXP_WAIT, "R1 power-up restarts", n, EXP_WAIT);
        do_op(1'b0, 21'h1FFF34, 8'h3C);

        report();
        $finish;
    end
endmodule